// File: doc/BRIEF.md
# Dual-Threshold Neighbour-Gated Strip Hit Recorder

This block turns the comparator outputs of a bank of silicon-strip channels into timestamped edge records. Every strip brings two comparator levels: a high-threshold one, whose threshold is set to keep noise hits rare, and a low-threshold one, which picks up the smaller share of charge that spreads onto adjacent strips. The block samples both levels once per readout tick, given by the `stb` strobe, and detects rising and falling edges. It writes one record for every edge of a high comparator. A low-comparator edge is written only when high-comparator activity is close by, both in strip position and in time. Because both the leading and the trailing edge of a pulse are kept, downstream logic can take the pulse height as the time over threshold: the trailing stamp minus the leading stamp.

Edges found on one tick are written one at a time into an output FIFO by a scan state machine. The machine has two states. `ST_IDLE` moves to `ST_SCAN` on a strobe. `ST_SCAN` steps through 4·NCH slots, one per cycle, then returns to `ST_IDLE`; a new strobe during a scan restarts the scan. Low-comparator edges are held back WIN ticks before the keep-or-discard decision is made, so a high hit that arrives up to WIN ticks later can still qualify them. Consecutive strobes must be more than 4·NCH clock cycles apart. The channel count is a parameter and covers both small prototype banks and large production banks.

Top module: `hitrec_top`

## Requirements
- R1: A synchronous active-high `rst` empties the FIFO (`rd_valid`=0), clears `ovf` and `drop_cnt`, and restarts the timestamp, so the first strobe after reset is stamped 0.
- R2: Every rising and every falling edge of a high comparator between consecutive strobes produces one record of type high. Its timestamp is the index of the strobe that saw the edge.
- R3: A low-comparator edge seen on strobe t of channel c is recorded, with timestamp t, only if the high comparator of channel c-1, c or c+1 was sampled high on some strobe from t-WIN to t+WIN. Otherwise it is discarded.
- R4: Strips 0 and NCH-1 are gated only by themselves and their single neighbour. Strip numbers do not wrap around.
- R5: `rd_data` is laid out MSB to LSB as {channel index, type (1 = high comparator), polarity (1 = rising/leading), timestamp}.
- R6: Records leave in scan order: ascending channel, and within a channel high-lead, high-trail, low-lead, low-trail. A low edge is written in the scan of the strobe WIN ticks after it was seen.
- R7: The timestamp counts strobes modulo 2^TSW and wraps silently.
- R8: A record that finds the FIFO full is dropped. The drop sets the sticky `ovf` flag and increments `drop_cnt`, which saturates. `ovf_clr` clears both.
- R9: The read port is first-in first-out. `rd_data` holds steady while `rd_valid` is high and `rd_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| stb | input | 1 | One-cycle readout-tick strobe |
| hi_cmp | input | NCH | High-threshold comparator levels |
| lo_cmp | input | NCH | Low-threshold comparator levels |
| ovf_clr | input | 1 | Clears overflow flag and drop count |
| rd_ready | input | 1 | Consumer accepts a record |
| rd_valid | output | 1 | A record is available |
| rd_data | output | CW+2+TSW | Record {channel, type, polarity, timestamp} |
| ovf | output | 1 | Sticky overflow flag |
| drop_cnt | output | DCW | Saturating count of dropped records |

## Verification
The bench drives directed patterns and a long pseudo-random sweep on 8 strips. A model that keeps every sampled level predicts every record. The corner cases it targets are:
- A low edge exactly WIN+1 ticks before a high hit. A gate with the window one tick too wide would keep it.
- A low edge on strip NCH-1 while only strip 0 is high. Neighbour logic that wraps around would emit a record here.
- Every strip switching on the same tick. An order-of-scan bug would reorder these records.
- Timestamps past the 2^TSW wrap, and low-edge stamps taken from the delayed tick. A design that stamps with the decision tick would be off by WIN.
- Deliberate FIFO overflow. A design that overwrote entries or miscounted drops would return the wrong records or show the wrong `drop_cnt`.

// File: rtl/hitrec_pkg.sv
package hitrec_pkg;
    typedef enum logic {ST_IDLE, ST_SCAN} scan_st_e;

    // slot order inside one channel during a scan
    localparam logic [1:0] SLOT_HI_LEAD  = 2'd0;
    localparam logic [1:0] SLOT_HI_TRAIL = 2'd1;
    localparam logic [1:0] SLOT_LO_LEAD  = 2'd2;
    localparam logic [1:0] SLOT_LO_TRAIL = 2'd3;
endpackage

// File: rtl/hitrec_chan.sv
module hitrec_chan #(
    parameter int WIN = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           stb,
    input  logic           hi,
    input  logic           lo,
    output logic           hi_rise,
    output logic           hi_fall,
    output logic [2*WIN:0] hi_win,
    output logic           lo_rise_d,
    output logic           lo_fall_d
);
    logic             hi_q, lo_q;
    logic [2*WIN-1:0] hist;
    logic [WIN-1:0]   dr, df;

    assign hi_rise   = hi & ~hi_q;
    assign hi_fall   = ~hi & hi_q;
    assign hi_win    = {hist, hi};
    assign lo_rise_d = dr[WIN-1];
    assign lo_fall_d = df[WIN-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= 1'b0;
            lo_q <= 1'b0;
            hist <= '0;
            dr   <= '0;
            df   <= '0;
        end else if (stb) begin
            hi_q <= hi;
            lo_q <= lo;
            for (int i = 2*WIN-1; i > 0; i--) hist[i] <= hist[i-1];
            hist[0] <= hi;
            for (int i = WIN-1; i > 0; i--) begin
                dr[i] <= dr[i-1];
                df[i] <= df[i-1];
            end
            dr[0] <= lo & ~lo_q;
            df[0] <= ~lo & lo_q;
        end
    end
endmodule

// File: rtl/hitrec_fifo.sv
module hitrec_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic          full,
    input  logic          rd_ready,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   cnt;
    logic          push, pop;

    assign full     = (cnt == (AW+1)'(DEPTH));
    assign rd_valid = (cnt != '0);
    assign rd_data  = mem[rp];
    assign push     = wr_en & ~full;
    assign pop      = rd_valid & rd_ready;

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= wp + 1'b1;
            if (pop)  rp <= rp + 1'b1;
            cnt <= cnt + (AW+1)'(push) - (AW+1)'(pop);
        end
    end
endmodule

// File: rtl/hitrec_top.sv
module hitrec_top
    import hitrec_pkg::*;
#(
    parameter int NCH   = 8,
    parameter int TSW   = 12,
    parameter int WIN   = 2,
    parameter int DEPTH = 32,
    parameter int DCW   = 8,
    localparam int CW   = $clog2(NCH),
    localparam int RW   = CW + 2 + TSW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           stb,
    input  logic [NCH-1:0] hi_cmp,
    input  logic [NCH-1:0] lo_cmp,
    input  logic           ovf_clr,
    input  logic           rd_ready,
    output logic           rd_valid,
    output logic [RW-1:0]  rd_data,
    output logic           ovf,
    output logic [DCW-1:0] drop_cnt
);
    localparam int SW = $clog2(4*NCH);
    localparam logic [SW-1:0] LAST = SW'(4*NCH-1);

    logic [NCH-1:0] hr, hf, ldr, ldf, near;
    logic [2*WIN:0] hwin [NCH];

    // per-strip edge detection, high history and low delay line
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        hitrec_chan #(.WIN(WIN)) u_ch (
            .clk(clk), .rst(rst), .stb(stb),
            .hi(hi_cmp[g]), .lo(lo_cmp[g]),
            .hi_rise(hr[g]), .hi_fall(hf[g]), .hi_win(hwin[g]),
            .lo_rise_d(ldr[g]), .lo_fall_d(ldf[g])
        );
        if (g == 0) begin : g_lo_end
            assign near[g] = (|hwin[g]) | (|hwin[g+1]);
        end else if (g == NCH-1) begin : g_hi_end
            assign near[g] = (|hwin[g]) | (|hwin[g-1]);
        end else begin : g_mid
            assign near[g] = (|hwin[g-1]) | (|hwin[g]) | (|hwin[g+1]);
        end
    end

    // timestamp and pending edges latched on each strobe
    logic [TSW-1:0] ts, ts_hi_q, ts_lo_q;
    logic [NCH-1:0] p_hr, p_hf, p_lr, p_lf;

    always_ff @(posedge clk) begin
        if (rst) begin
            ts      <= '0;
            ts_hi_q <= '0;
            ts_lo_q <= '0;
            p_hr    <= '0;
            p_hf    <= '0;
            p_lr    <= '0;
            p_lf    <= '0;
        end else if (stb) begin
            ts      <= ts + 1'b1;
            ts_hi_q <= ts;
            ts_lo_q <= ts - TSW'(WIN);
            p_hr    <= hr;
            p_hf    <= hf;
            p_lr    <= ldr & near;
            p_lf    <= ldf & near;
        end
    end

    // scan state machine
    scan_st_e       state, state_nx;
    logic [SW-1:0]  sidx;
    logic [CW-1:0]  ch_sel;
    logic [1:0]     slot;
    logic           wr_en, full;
    logic [RW-1:0]  rec;

    assign ch_sel = sidx[SW-1:2];
    assign slot   = sidx[1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            sidx  <= '0;
        end else begin
            state <= state_nx;
            if (stb)                    sidx <= '0;
            else if (state == ST_SCAN)  sidx <= sidx + 1'b1;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (stb) state_nx = ST_SCAN;
            ST_SCAN: if (!stb && sidx == LAST) state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        wr_en = 1'b0;
        rec   = {ch_sel, ~slot[1], ~slot[0], (slot[1] ? ts_lo_q : ts_hi_q)};
        unique case (state)
            ST_IDLE: wr_en = 1'b0;
            ST_SCAN: begin
                unique case (slot)
                    SLOT_HI_LEAD:  wr_en = p_hr[ch_sel];
                    SLOT_HI_TRAIL: wr_en = p_hf[ch_sel];
                    SLOT_LO_LEAD:  wr_en = p_lr[ch_sel];
                    SLOT_LO_TRAIL: wr_en = p_lf[ch_sel];
                endcase
            end
        endcase
    end

    hitrec_fifo #(.DW(RW), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(rec), .full(full),
        .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    // overflow bookkeeping
    always_ff @(posedge clk) begin
        if (rst || ovf_clr) begin
            ovf      <= 1'b0;
            drop_cnt <= '0;
        end else if (wr_en && full) begin
            ovf <= 1'b1;
            if (drop_cnt != '1) drop_cnt <= drop_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/hitrec_chk.sv
module hitrec_chk #(
    parameter int RW  = 8,
    parameter int DCW = 8
) (
    input logic           clk,
    input logic           rst,
    input logic           ovf_clr,
    input logic           rd_ready,
    input logic           rd_valid,
    input logic [RW-1:0]  rd_data,
    input logic           ovf,
    input logic [DCW-1:0] drop_cnt
);
    AST_RESET_EMPTY: assert property (@(posedge clk) rst |=> !rd_valid && !ovf); // R1

    AST_READ_HOLD: assert property (@(posedge clk) disable iff (rst)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_data)); // R9

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        ovf && !ovf_clr |=> ovf); // R8

    AST_DROP_MONO: assert property (@(posedge clk) disable iff (rst)
        !ovf_clr |=> drop_cnt >= $past(drop_cnt)); // R8

    AST_DROP_FLAG: assert property (@(posedge clk) disable iff (rst)
        drop_cnt != '0 |-> ovf); // R8
endmodule

bind hitrec_top hitrec_chk #(.RW(RW), .DCW(DCW)) u_chk (
    .clk(clk), .rst(rst), .ovf_clr(ovf_clr), .rd_ready(rd_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .ovf(ovf), .drop_cnt(drop_cnt)
);

// File: tb/sim_hitrec_top.sv
module sim_hitrec_top;
    localparam int NCH = 8, TSW = 5, WIN = 2, DEPTH = 16, DCW = 4;
    localparam int CW = 3, RW = CW + 2 + TSW;
    localparam int PER = 40;
    localparam int MAXT = 400;

    logic clk = 1'b0, rst = 1'b1, stb = 1'b0, ovf_clr = 1'b0, rd_ready = 1'b1;
    logic [NCH-1:0] hi_cmp = '0, lo_cmp = '0;
    logic rd_valid, ovf;
    logic [RW-1:0] rd_data;
    logic [DCW-1:0] drop_cnt;

    hitrec_top #(.NCH(NCH), .TSW(TSW), .WIN(WIN), .DEPTH(DEPTH), .DCW(DCW)) u0 (
        .clk(clk), .rst(rst), .stb(stb), .hi_cmp(hi_cmp), .lo_cmp(lo_cmp),
        .ovf_clr(ovf_clr), .rd_ready(rd_ready), .rd_valid(rd_valid),
        .rd_data(rd_data), .ovf(ovf), .drop_cnt(drop_cnt)
    );

    always #10 clk = ~clk;

    int checks = 0, errors = 0, T = 0;
    bit done = 1'b0;
    logic [NCH-1:0] hi_lv [MAXT];
    logic [NCH-1:0] lo_lv [MAXT];
    logic [RW-1:0] exp_q [$];
    string tag_q [$];

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    function automatic logic [RW-1:0] mk(int c, bit ty, bit pol, int t);
        return {c[CW-1:0], ty, pol, t[TSW-1:0]};
    endfunction

    function automatic bit near_hi(int t, int c);
        for (int u = t - WIN; u <= t + WIN; u++)
            for (int cc = c - 1; cc <= c + 1; cc++)
                if (u >= 0 && cc >= 0 && cc < NCH && hi_lv[u][cc]) return 1'b1;
        return 1'b0;
    endfunction

    // expected records for the scan that follows strobe number tt
    task automatic model(input int tt);
        for (int c = 0; c < NCH; c++) begin
            bit hp, hc, lp, lc;
            int t;
            hc = hi_lv[tt][c];
            hp = (tt > 0) ? hi_lv[tt-1][c] : 1'b0;
            if (hc && !hp) begin exp_q.push_back(mk(c, 1, 1, tt)); tag_q.push_back("R2"); end
            if (!hc && hp) begin exp_q.push_back(mk(c, 1, 0, tt)); tag_q.push_back("R2"); end
            t = tt - WIN;
            if (t >= 0) begin
                lc = lo_lv[t][c];
                lp = (t > 0) ? lo_lv[t-1][c] : 1'b0;
                if (lc != lp && near_hi(t, c)) begin
                    exp_q.push_back(mk(c, 0, lc, t));
                    tag_q.push_back((c == 0 || c == NCH-1) ? "R4" : "R3");
                end
            end
        end
    endtask

    task automatic tick(input logic [NCH-1:0] hv, input logic [NCH-1:0] lv);
        @(posedge clk); #2;
        hi_cmp = hv; lo_cmp = lv;
        hi_lv[T] = hv; lo_lv[T] = lv;
        model(T);
        stb = 1'b1;
        @(posedge clk); #2;
        stb = 1'b0;
        repeat (PER - 2) @(posedge clk);
        T++;
    endtask

    task automatic seg(input logic [NCH-1:0] hv, input logic [NCH-1:0] lv, input int n);
        for (int i = 0; i < n; i++) tick(hv, lv);
    endtask

    // output monitor: every transfer compared against the model
    always @(negedge clk) begin
        if (!rst && rd_valid && rd_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3 R4 unexpected record", int'(rd_data), 0);
            end else begin
                logic [RW-1:0] e;
                string tg;
                e = exp_q.pop_front();
                tg = tag_q.pop_front();
                chk(rd_data == e, {tg, " R5 R6 R7 record"}, int'(rd_data), int'(e));
            end
        end
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog expired: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        chk(rd_valid == 1'b0, "R1 rd_valid after reset", int'(rd_valid), 0);
        chk(ovf == 1'b0, "R1 ovf after reset", int'(ovf), 0);
        chk(drop_cnt == '0, "R1 drop_cnt after reset", int'(drop_cnt), 0);

        seg('0, '0, 3);
        // low pulse wider than a high pulse on the same strip
        seg('0, 8'h08, 1); seg(8'h08, 8'h08, 3); seg('0, 8'h08, 1); seg('0, '0, 4);
        // low far from any high: discarded
        seg(8'h01, 8'h20, 2); seg('0, '0, 4);
        // low leads high by WIN+1: leading dropped, trailing kept
        seg('0, 8'h04, 3); seg(8'h04, 8'h04, 1); seg('0, '0, 5);
        // edge strips, no wrap-around neighbour
        seg(8'h01, 8'h82, 2); seg('0, '0, 4);
        seg(8'h80, 8'h41, 2); seg('0, '0, 4);
        // all strips on the same tick
        seg(8'hFF, 8'hFF, 2); seg('0, '0, 4);
        chk(exp_q.size() == 0, "R6 directed records all delivered", exp_q.size(), 0);

        // pseudo-random sweep
        r = 32'h1ACE_B00C;
        for (int i = 0; i < 200; i++) begin
            logic [NCH-1:0] hv;
            r = {r[30:0], r[31] ^ r[21] ^ r[1] ^ r[0]};
            r = {r[30:0], r[31] ^ r[21] ^ r[1] ^ r[0]};
            hv = r[7:0] & r[15:8] & r[23:16];
            tick(hv, hv | (r[31:24] & r[15:8]));
        end
        seg('0, '0, 4);
        chk(exp_q.size() == 0, "R7 sweep records all delivered", exp_q.size(), 0);
        chk(T > 2 ** TSW, "R7 sweep passed a timestamp wrap", T, 2 ** TSW);

        // overflow
        @(posedge clk); #2 rd_ready = 1'b0;
        tick(8'hFF, '0); tick('0, '0); tick(8'hFF, '0);
        @(negedge clk);
        chk(ovf == 1'b1, "R8 ovf set on full", int'(ovf), 1);
        chk(int'(drop_cnt) == exp_q.size() - DEPTH, "R8 drop count",
            int'(drop_cnt), exp_q.size() - DEPTH);
        chk(rd_valid == 1'b1, "R9 data waiting while stalled", int'(rd_valid), 1);
        while (exp_q.size() > DEPTH) begin
            void'(exp_q.pop_back());
            void'(tag_q.pop_back());
        end
        @(posedge clk); #2 rd_ready = 1'b1;
        repeat (PER) @(posedge clk);
        @(negedge clk);
        chk(exp_q.size() == 0, "R9 kept records drained in order", exp_q.size(), 0);
        chk(rd_valid == 1'b0, "R9 FIFO empty after drain", int'(rd_valid), 0);
        chk(ovf == 1'b1, "R8 ovf sticky", int'(ovf), 1);
        @(posedge clk); #2 ovf_clr = 1'b1;
        @(posedge clk); #2 ovf_clr = 1'b0;
        @(negedge clk);
        chk(ovf == 1'b0, "R8 ovf cleared", int'(ovf), 0);
        chk(drop_cnt == '0, "R8 drop_cnt cleared", int'(drop_cnt), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule